// File: doc/BRIEF.md
# Post-Retirement Store Queue with Speculative Atomic Commit

This block sits between retirement and the L1 data cache. Retired stores enter a small in-order queue and leave it one at a time through the cache write port. Most entries are ordinary stores, and once such a store is in the queue it is certain to be written. A locked read-modify-write may also retire into the queue before its store is globally visible. For that case the block keeps a small set of line monitors. The load half of the atomic arms a monitor with its 64-byte line. Any invalidation or eviction snoop to that line marks the monitor as lost.

When a locked entry reaches the head of the queue and the cache can accept a write, the block checks its monitor. If exclusive ownership held from the arming load up to that cycle, the store is written like any other. If ownership was lost, the store is not written. Instead the block pulses a rollback request that carries the entry's checkpoint tag, and it discards the locked entry together with every younger entry in the same cycle. The core then restores its checkpoint and executes and retires those instructions again. A retire counter counts every retire pulse, replays included, so it can run ahead of the architectural instruction count.

Top module: `spec_store_commit`

## Requirements
- R1: The write port always presents the oldest queued entry. An ordinary head is offered with `wr_valid` high and leaves the queue on a cycle with `wr_ready` high. While it waits, its address and data stay stable.
- R2: `alloc_ready` is low when the queue holds DEPTH (default 8) entries and during a rollback cycle. An `alloc_valid` seen while `alloc_ready` is low is dropped.
- R3: An ordinary entry is never cancelled. `rb_valid` is never raised while the head entry is ordinary, even when snoops hit its line.
- R4: A locked head whose monitor slot was armed, with no matching snoop since then, is offered on the write port. It is written on a cycle with `wr_ready` high, and that write releases the slot.
- R5: A locked head whose monitor saw a matching snoop is not offered (`wr_valid` low). On the first cycle with `wr_ready` high, `rb_valid` is high for exactly one cycle and `rb_tag` carries that entry's checkpoint tag.
- R6: A snoop that matches the head's monitored line in the same cycle as the commit attempt counts as a loss and causes a rollback instead of the write.
- R7: In the rollback cycle, the locked entry and all younger entries are discarded and all monitor slots are released. On the next cycle the queue is empty.
- R8: Snoops compare line addresses only (address bits from bit 6 upward). A snoop to a different line leaves a monitor intact.
- R9: A locked entry whose slot is not armed at its commit attempt is treated as lost. This covers a slot that was never armed, one released by an earlier commit, and one released by a rollback.
- R10: `retire_count` increments by one on each cycle with `retire_pulse` high and wraps at its width.
- R11: Re-arming a slot clears its lost state, unless a matching snoop arrives in the arming cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | A retired store is offered to the queue |
| alloc_ready | output | 1 | Queue accepts the offered store this cycle |
| alloc_locked | input | 1 | Offered store belongs to a locked atomic |
| alloc_slot | input | SLOT_W | Monitor slot of a locked store |
| alloc_tag | input | TAG_W | Checkpoint tag of the store |
| alloc_addr | input | ADDR_W | Byte address of the store |
| alloc_data | input | DATA_W | Store data |
| arm_valid | input | 1 | An atomic load executed and arms a monitor |
| arm_slot | input | SLOT_W | Slot to arm |
| arm_addr | input | ADDR_W | Address of the atomic load |
| snoop_valid | input | 1 | Invalidation or eviction of a line |
| snoop_addr | input | ADDR_W | Address of the snooped line |
| wr_valid | output | 1 | Head store is offered to the cache |
| wr_ready | input | 1 | Cache accepts a write this cycle |
| wr_addr | output | ADDR_W | Head store address |
| wr_data | output | DATA_W | Head store data |
| rb_valid | output | 1 | Rollback request, one cycle |
| rb_tag | output | TAG_W | Checkpoint to restore, valid with rb_valid |
| retire_pulse | input | 1 | One instruction retired this cycle |
| retire_count | output | CNT_W | Retired-instruction count, replays included |

## Verification
The bench uses the default build: a depth of 8, four monitor slots, 32-bit addresses and data, 6-bit tags and a 16-bit counter. With a queue that shallow, the full stall and the full-queue flush both come up often. With only four slots, random locked stores regularly pick slots that are unarmed or already released. Random addresses are drawn from eight lines, so snoops often hit monitored lines, including in the exact cycle of a commit attempt.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
   typedef enum logic [1:0] {
      HEAD_IDLE   = 2'd0,
      HEAD_DRAIN  = 2'd1,
      HEAD_COMMIT = 2'd2,
      HEAD_REVOKE = 2'd3
   } head_act_e;
endpackage

// File: rtl/ssc_fifo.sv
module ssc_fifo #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   input  logic             flush,
   output logic             head_valid,
   output logic [WIDTH-1:0] head_data,
   output logic [CNT_W-1:0] count,
   output logic             full
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ssc_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr, wr_ptr;

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= step(wr_ptr);
         if (pop)  rd_ptr <= step(rd_ptr);
         count <= count + CNT_W'(push) - CNT_W'(pop);
      end
   end

   assign head_valid = (count != '0);
   assign head_data  = mem[rd_ptr];
   assign full       = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/ssc_line_monitor.sv
module ssc_line_monitor #(
   parameter int SLOTS  = 4,
   parameter int LINE_W = 26,
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_valid,
   input  logic [SLOT_W-1:0] arm_slot,
   input  logic [LINE_W-1:0] arm_line,
   input  logic              snoop_valid,
   input  logic [LINE_W-1:0] snoop_line,
   input  logic              rel_valid,
   input  logic [SLOT_W-1:0] rel_slot,
   input  logic              clear_all,
   input  logic [SLOT_W-1:0] query_slot,
   output logic              query_lost
);
   generate
      if (SLOTS < 1) begin : g_bad_slots
         $error("ssc_line_monitor: SLOTS must be at least 1");
      end
   endgenerate

   logic [SLOTS-1:0] slot_lost;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic              act_q, lost_q;
      logic [LINE_W-1:0] line_q;
      logic              arm_hit, rel_hit, snoop_hit;

      assign arm_hit   = arm_valid && (arm_slot == SLOT_W'(s));
      assign rel_hit   = rel_valid && (rel_slot == SLOT_W'(s));
      assign snoop_hit = snoop_valid && (snoop_line == line_q);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            act_q  <= 1'b0;
            lost_q <= 1'b0;
            line_q <= '0;
         end else if (arm_hit) begin
            act_q  <= 1'b1;
            line_q <= arm_line;
            lost_q <= snoop_valid && (snoop_line == arm_line);
         end else if (clear_all || rel_hit) begin
            act_q  <= 1'b0;
         end else if (act_q && snoop_hit) begin
            lost_q <= 1'b1;
         end
      end

      assign slot_lost[s] = !act_q || lost_q || snoop_hit;
   end

   assign query_lost = slot_lost[query_slot];
endmodule

// File: rtl/ssc_retire_counter.sv
module ssc_retire_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pulse,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n)     count <= '0;
      else if (pulse) count <= count + 1'b1;
   end
endmodule

// File: rtl/spec_store_commit.sv
module spec_store_commit #(
   parameter int DEPTH    = 8,
   parameter int SLOTS    = 4,
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int TAG_W    = 6,
   parameter int CNT_W    = 16,
   parameter int LINE_OFS = 6,
   localparam int SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int LINE_W  = ADDR_W - LINE_OFS,
   localparam int QCNT_W  = $clog2(DEPTH + 1),
   localparam int ENT_W   = 1 + SLOT_W + TAG_W + ADDR_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   output logic              alloc_ready,
   input  logic              alloc_locked,
   input  logic [SLOT_W-1:0] alloc_slot,
   input  logic [TAG_W-1:0]  alloc_tag,
   input  logic [ADDR_W-1:0] alloc_addr,
   input  logic [DATA_W-1:0] alloc_data,
   input  logic              arm_valid,
   input  logic [SLOT_W-1:0] arm_slot,
   input  logic [ADDR_W-1:0] arm_addr,
   input  logic              snoop_valid,
   input  logic [ADDR_W-1:0] snoop_addr,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              rb_valid,
   output logic [TAG_W-1:0]  rb_tag,
   input  logic              retire_pulse,
   output logic [CNT_W-1:0]  retire_count
);
   import ssc_pkg::*;

   generate
      if (LINE_OFS < 1 || LINE_OFS >= ADDR_W) begin : g_bad_line
         $error("spec_store_commit: LINE_OFS out of range");
      end
   endgenerate

   logic [ENT_W-1:0]  push_ent, head_ent;
   logic              head_valid, q_full, push, pop, revoke;
   logic [QCNT_W-1:0] q_count;
   logic              head_locked, head_lost;
   logic [SLOT_W-1:0] head_slot;
   head_act_e         head_act;

   assign push_ent = {alloc_locked, alloc_slot, alloc_tag, alloc_addr, alloc_data};
   assign {head_locked, head_slot, rb_tag, wr_addr, wr_data} = head_ent;

   ssc_fifo #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (push_ent),
      .pop       (pop),
      .flush     (revoke),
      .head_valid(head_valid),
      .head_data (head_ent),
      .count     (q_count),
      .full      (q_full)
   );

   ssc_line_monitor #(.SLOTS(SLOTS), .LINE_W(LINE_W)) u_monitor (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_valid  (arm_valid),
      .arm_slot   (arm_slot),
      .arm_line   (arm_addr[ADDR_W-1:LINE_OFS]),
      .snoop_valid(snoop_valid),
      .snoop_line (snoop_addr[ADDR_W-1:LINE_OFS]),
      .rel_valid  (pop && head_locked),
      .rel_slot   (head_slot),
      .clear_all  (revoke),
      .query_slot (head_slot),
      .query_lost (head_lost)
   );

   ssc_retire_counter #(.CNT_W(CNT_W)) u_retired (
      .clk  (clk),
      .rst_n(rst_n),
      .pulse(retire_pulse),
      .count(retire_count)
   );

   always_comb begin
      if (!head_valid)       head_act = HEAD_IDLE;
      else if (!head_locked) head_act = HEAD_DRAIN;
      else if (head_lost)    head_act = HEAD_REVOKE;
      else                   head_act = HEAD_COMMIT;
   end

   assign wr_valid    = (head_act == HEAD_DRAIN) || (head_act == HEAD_COMMIT);
   assign revoke      = (head_act == HEAD_REVOKE) && wr_ready;
   assign rb_valid    = revoke;
   assign pop         = wr_valid && wr_ready;
   assign alloc_ready = !q_full && !revoke;
   assign push        = alloc_valid && alloc_ready;
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   localparam int QCNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              alloc_ready,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              rb_valid,
   input logic              retire_pulse,
   input logic [CNT_W-1:0]  retire_count,
   input logic [QCNT_W-1:0] q_count,
   input logic              head_valid,
   input logic              head_locked
);
   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (q_count == QCNT_W'(DEPTH)) |-> !alloc_ready); // R2

   AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready && head_valid && !head_locked)
      |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R1

   AST_ORDINARY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid && !head_locked) |-> !rb_valid); // R3

   AST_REVOKE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      rb_valid |-> !wr_valid); // R5

   AST_REVOKE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      rb_valid |=> (q_count == '0) && !rb_valid && !wr_valid); // R7

   AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      retire_pulse |=> (retire_count == $past(retire_count) + 1'b1)); // R10

   AST_RETIRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !retire_pulse |=> $stable(retire_count)); // R10
endmodule

bind spec_store_commit ssc_checker #(
   .DEPTH (DEPTH),
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .alloc_ready (alloc_ready),
   .wr_valid    (wr_valid),
   .wr_ready    (wr_ready),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .rb_valid    (rb_valid),
   .retire_pulse(retire_pulse),
   .retire_count(retire_count),
   .q_count     (q_count),
   .head_valid  (head_valid),
   .head_locked (head_locked)
);

// File: tb/spec_store_commit_test.sv
module spec_store_commit_test;
   localparam int DEPTH = 8, SLOTS = 4, AW = 32, DW = 32, TW = 6, CW = 16, OFS = 6;
   localparam int SW = 2;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          alloc_valid, alloc_locked, alloc_ready;
   logic [SW-1:0] alloc_slot, arm_slot;
   logic [TW-1:0] alloc_tag, rb_tag;
   logic [AW-1:0] alloc_addr, arm_addr, snoop_addr, wr_addr;
   logic [DW-1:0] alloc_data, wr_data;
   logic          arm_valid, snoop_valid, wr_valid, wr_ready, rb_valid, retire_pulse;
   logic [CW-1:0] retire_count;

   always #5 clk = ~clk;

   spec_store_commit uut (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_locked(alloc_locked),
      .alloc_slot(alloc_slot), .alloc_tag(alloc_tag), .alloc_addr(alloc_addr),
      .alloc_data(alloc_data), .arm_valid(arm_valid), .arm_slot(arm_slot),
      .arm_addr(arm_addr), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .rb_valid(rb_valid), .rb_tag(rb_tag), .retire_pulse(retire_pulse),
      .retire_count(retire_count)
   );

   typedef struct packed {
      logic          locked;
      logic [SW-1:0] slot;
      logic [TW-1:0] tag;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
   } ent_t;

   ent_t                mq[$];
   bit                  m_act[SLOTS];
   bit                  m_lost[SLOTS];
   logic [AW-OFS-1:0]   m_line[SLOTS];
   logic [CW-1:0]       m_cnt;
   int                  n_tests = 0, n_fail = 0;
   string               scen = "reset";
   bit                  done = 1'b0;

   function automatic logic [AW-OFS-1:0] line_of(input logic [AW-1:0] a);
      return a[AW-1:OFS];
   endfunction

   // R8: only line bits take part in the match
   function automatic bit lost_now(input int s);
      return !m_act[s] || m_lost[s] ||
             (snoop_valid && line_of(snoop_addr) == m_line[s]);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s [%s] %s: actual %0h expected %0h", req, scen, what, act, exp);
      end
   endtask

   task automatic idle();
      alloc_valid = 0; alloc_locked = 0; alloc_slot = 0; alloc_tag = 0;
      alloc_addr = 0; alloc_data = 0; arm_valid = 0; arm_slot = 0; arm_addr = 0;
      snoop_valid = 0; snoop_addr = 0; wr_ready = 0; retire_pulse = 0;
   endtask

   // Called at a falling edge with inputs set: compare, then advance the model.
   task automatic cycle();
      bit   e_wv, e_rb, e_ready, hl;
      ent_t h;
      #1;
      h = '0; hl = 1'b0;
      if (mq.size() > 0) begin
         h  = mq[0];
         hl = h.locked && lost_now(int'(h.slot));
      end
      e_wv    = (mq.size() > 0) && !hl;
      e_rb    = (mq.size() > 0) && hl && wr_ready;
      e_ready = (mq.size() < DEPTH) && !e_rb;
      chk(alloc_ready === e_ready, "R2", "alloc_ready", 64'(alloc_ready), 64'(e_ready));
      chk(wr_valid === e_wv, h.locked ? "R4" : "R1", "wr_valid", 64'(wr_valid), 64'(e_wv));
      if (e_wv)
         chk({wr_addr, wr_data} === {h.addr, h.data}, h.locked ? "R4" : "R1",
             "wr addr/data", {wr_addr, wr_data}, {h.addr, h.data});
      chk(rb_valid === e_rb, h.locked ? "R5" : "R3", "rb_valid", 64'(rb_valid), 64'(e_rb));
      if (e_rb) chk(rb_tag === h.tag, "R5", "rb_tag", 64'(rb_tag), 64'(h.tag));
      chk(retire_count === m_cnt, "R10", "retire_count", 64'(retire_count), 64'(m_cnt));

      // model update
      for (int s = 0; s < SLOTS; s++) begin
         bit hit;
         hit = snoop_valid && (line_of(snoop_addr) == m_line[s]);
         if (arm_valid && arm_slot == SW'(s)) begin
            m_act[s]  = 1'b1;
            m_line[s] = line_of(arm_addr);
            m_lost[s] = snoop_valid && (line_of(snoop_addr) == line_of(arm_addr));
         end else if (e_rb || (e_wv && wr_ready && h.locked && h.slot == SW'(s))) begin
            m_act[s] = 1'b0;
         end else if (m_act[s] && hit) begin
            m_lost[s] = 1'b1;
         end
      end
      if (e_rb) mq.delete();
      else if (e_wv && wr_ready) void'(mq.pop_front());
      if (alloc_valid && e_ready)
         mq.push_back('{alloc_locked, alloc_slot, alloc_tag, alloc_addr, alloc_data});
      if (retire_pulse) m_cnt = m_cnt + 1'b1;
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   function automatic logic [AW-1:0] rand_addr();
      return {20'hA5C00, 6'($urandom_range(0, 7)), 6'($urandom)};
   endfunction

   task automatic put(input bit lk, input int slot, input int tag,
                      input logic [AW-1:0] a, input logic [DW-1:0] d, input bit rdy);
      alloc_valid = 1; alloc_locked = lk; alloc_slot = SW'(slot);
      alloc_tag = TW'(tag); alloc_addr = a; alloc_data = d; wr_ready = rdy;
      cycle();
   endtask

   task automatic arm(input int slot, input logic [AW-1:0] a);
      arm_valid = 1; arm_slot = SW'(slot); arm_addr = a;
      cycle();
   endtask

   task automatic drain(input int n);
      for (int i = 0; i < n; i++) begin wr_ready = 1; cycle(); end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      idle();
      mq.delete(); m_cnt = '0;
      for (int s = 0; s < SLOTS; s++) begin m_act[s] = 0; m_lost[s] = 0; m_line[s] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      cycle();                                  // reset state

      scen = "R2 fill";
      for (int i = 0; i < DEPTH + 2; i++) put(0, 0, i, 32'h1000 + i * 4, 32'hD000 + i, 0);
      scen = "R1 drain";
      drain(DEPTH + 1);

      scen = "R4 clean commit";
      arm(0, 32'h0000_2040);
      put(1, 0, 3, 32'h0000_2048, 32'hCAFE, 0);
      drain(2);

      scen = "R5 snoop then commit attempt";
      arm(1, 32'h0000_3000);
      put(1, 1, 5, 32'h0000_3004, 32'hBAD1, 0);
      put(0, 0, 6, 32'h0000_4000, 32'h1111, 0);
      put(0, 0, 7, 32'h0000_4040, 32'h2222, 0);
      snoop_valid = 1; snoop_addr = 32'h0000_303C; cycle();
      cycle();                                  // head lost, cache busy: wait
      drain(3);                                 // R7 flush of younger entries

      scen = "R6 same-cycle snoop";
      arm(2, 32'h0000_5000);
      put(1, 2, 9, 32'h0000_5010, 32'h3333, 0);
      wr_ready = 1; snoop_valid = 1; snoop_addr = 32'h0000_5020; cycle();
      drain(1);

      scen = "R8 other-line snoop";
      arm(3, 32'h0000_6000);
      put(1, 3, 11, 32'h0000_6000, 32'h4444, 0);
      snoop_valid = 1; snoop_addr = 32'h0000_6040; cycle();
      drain(2);

      scen = "R9 released slot";
      put(1, 3, 12, 32'h0000_6000, 32'h5555, 0);
      drain(2);
      scen = "R9 slot cleared by rollback";
      arm(2, 32'h0000_7000);
      arm(1, 32'h0000_7100);
      put(1, 1, 13, 32'h0000_7100, 32'h6666, 0);
      put(1, 2, 14, 32'h0000_7000, 32'h6667, 0);
      snoop_valid = 1; snoop_addr = 32'h0000_7100; cycle();
      drain(1);                                 // slot 1 revoked, slot 2 released
      put(1, 2, 15, 32'h0000_7000, 32'h6668, 0);
      drain(2);

      scen = "R11 re-arm";
      arm(1, 32'h0000_8000);
      snoop_valid = 1; snoop_addr = 32'h0000_8000; cycle();
      arm(1, 32'h0000_8000);
      put(1, 1, 16, 32'h0000_8008, 32'h7777, 0);
      drain(2);
      arm_valid = 1; arm_slot = 1; arm_addr = 32'h0000_8000;
      snoop_valid = 1; snoop_addr = 32'h0000_8010; cycle();
      put(1, 1, 17, 32'h0000_8008, 32'h7778, 0);
      drain(2);

      scen = "R3 snoop on ordinary";
      put(0, 0, 18, 32'h0000_9000, 32'h8888, 0);
      snoop_valid = 1; snoop_addr = 32'h0000_9000; wr_ready = 1; cycle();

      scen = "R10 retire burst";
      for (int i = 0; i < 20; i++) begin retire_pulse = 1; cycle(); end

      scen = "random";
      for (int i = 0; i < 4000; i++) begin
         alloc_valid  = ($urandom_range(0, 99) < 45);
         alloc_locked = ($urandom_range(0, 99) < 30);
         alloc_slot   = SW'($urandom);
         alloc_tag    = TW'($urandom);
         alloc_addr   = rand_addr();
         alloc_data   = $urandom;
         arm_valid    = ($urandom_range(0, 99) < 25);
         arm_slot     = SW'($urandom);
         arm_addr     = rand_addr();
         snoop_valid  = ($urandom_range(0, 99) < 8);
         snoop_addr   = rand_addr();
         wr_ready     = ($urandom_range(0, 99) < 40);
         retire_pulse = ($urandom_range(0, 99) < 60);
         cycle();
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule